// File: doc/BRIEF.md
# Super I/O Configuration Index/Data Port

This block is the configuration front end of a legacy multi-function I/O device on an 8-bit ISA-style bus. It occupies two adjacent byte addresses. The even address is an index port, which selects one of three configuration registers. The odd address is a data port, which reads or writes the selected register. The three registers are a function enable register, a function address map register and a power/test register. A 5-bit strap input picks their reset values from a fixed set of 32 configurations.

After reset, reads of the index port return a short identification sequence. After that sequence, or after any write to the index port, those reads return the selected index.

The block decodes the register contents into enable flags, legacy I/O base addresses and IRQ numbers for six functions: a parallel port, two UARTs, a floppy controller and an IDE controller. The controllers themselves use these outputs to place themselves on the bus. The power-down and test bits are stored but have no effect beyond the decode described below.

Top module: `sio_cfg_port`

## Requirements
- R1: While reset is asserted, the selected index becomes 0. The enable, map and power registers load the strap-selected defaults: strap 1 gives 0x4F/0x11/0x00, strap 31 gives 0x00/0x10/0x02, strap 0 gives 0x4F/0x10/0x00 and strap 6 gives 0x4B/0x00/0x00. Register index 0 is enable, 1 is map and 2 is power.
- R2: After reset, the first index-port read returns 0x88 and the second returns 0x00. Every later index-port read returns the selected index. Data-port accesses do not advance this sequence, and the sequence holds at its final state.
- R3: A write to the index port stores the written byte as the selected index and ends the identification sequence at once.
- R4: A data-port write updates the selected register when the index is 0, 1 or 2, and a data-port read returns it. With an index of 3 or above, writes are ignored and reads return 0x00.
- R5: rdata_o is 0x00 unless rd_i is high and addr_i[15:1] equals the base address (default 0x398) with bit 0 clear. Accesses at other addresses change no state. Address bit 0 selects the data port when set and the index port when clear.
- R6: Enable bit 0 enables the parallel port, bits 1 and 2 enable UART0 and UART1, bit 3 enables the floppy and bit 6 enables IDE. Enable bit 5 moves the floppy base from 0x3F0 to 0x370. Enable bit 7 moves the IDE base from 0x1F0 to 0x170. The IDE alternate base is the IDE base plus 0x206.
- R7: Map bits 1:0 set the parallel base: 0 gives 0x378, 1 gives 0x3BC, 2 gives 0x278, and 3 gives no base (0x000, IRQ 0). The parallel IRQ is 7 for field 1 and 5 for field 2. For field 0 it is 7 when power bit 3 is set and 5 otherwise.
- R8: UART n uses map field [2n+3:2n+2]. Field 0 gives 0x3F8 and field 1 gives 0x2F8. Map bits 7:6 (values 0..3) select the base for field 2 from 0x3E8/0x338/0x2E8/0x220 and for field 3 from 0x2E8/0x238/0x2E0/0x228. The UART IRQ is 3 for an odd field and 4 for an even one.
- R9: The floppy IRQ is always 6 and the IDE IRQ is always 14.
- R10: Register writes take effect at the clock edge of the write strobe. All decoded outputs reflect the new value in the following cycle and stay unchanged in cycles without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 5 | Reset configuration select |
| addr_i | input | 16 | Bus I/O address |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe, one byte per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when not selected |
| par_en_o | output | 1 | Parallel port enable |
| par_base_o | output | 16 | Parallel port base address |
| par_irq_o | output | 4 | Parallel port IRQ |
| uart_en_o | output | 2 | UART enables, bit n for UART n |
| uart_base_o | output | 2x16 | UART base addresses |
| uart_irq_o | output | 2x4 | UART IRQs |
| fdc_en_o | output | 1 | Floppy controller enable |
| fdc_base_o | output | 16 | Floppy base address |
| fdc_irq_o | output | 4 | Floppy IRQ |
| ide_en_o | output | 1 | IDE enable |
| ide_base_o | output | 16 | IDE command block base |
| ide_alt_base_o | output | 16 | IDE alternate status base |
| ide_irq_o | output | 4 | IDE IRQ |

## Verification
The properties assume that rd_i and wr_i are never high in the same cycle. They also assume that every bus input changes only away from the rising clock edge, so each strobe cycle counts as exactly one byte access. The stimulus drives all bus inputs at the falling edge and issues reads and writes as separate operations. It holds strap_i steady before it asserts reset, because a strap change during reset is not part of the defined behaviour. Decode sweeps cover all 256 map values under several enable patterns, and both settings of power bit 3.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int REG_NUM  = 3;
  localparam int UART_NUM = 2;
  localparam logic [7:0] ID_FIRST  = 8'h88;
  localparam logic [7:0] ID_SECOND = 8'h00;

  typedef enum logic [1:0] {
    ID_S0  = 2'd0,
    ID_S1  = 2'd1,
    ID_END = 2'd2
  } id_step_e;

  typedef struct packed {
    logic [7:0] pwr;
    logic [7:0] map;
    logic [7:0] fen;
  } cfg_regs_t;

  function automatic logic [7:0] strap_fen(input logic [4:0] s);
    if (s <= 5'd5)       return 8'h4F;
    else if (s <= 5'd11) return 8'h4B;
    else if (s <= 5'd15) return 8'h0F;
    else if (s <= 5'd19) return 8'h49;
    else if (s <= 5'd23) return 8'h07;
    else if (s <= 5'd29) return 8'h47;
    else if (s == 5'd30) return 8'h08;
    else                 return 8'h00;
  endfunction

  function automatic logic [7:0] strap_map(input logic [4:0] s);
    case (s)
      5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31: return 8'h10;
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:  return 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:               return 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:               return 8'h24;
      5'd5, 5'd29:                             return 8'h38;
      5'd7, 5'd8, 5'd17, 5'd18:                return 8'h01;
      5'd9:                                    return 8'h09;
      5'd10, 5'd11:                            return 8'h08;
      default:                                 return 8'h00;
    endcase
  endfunction

  function automatic cfg_regs_t strap_defaults(input logic [4:0] s);
    cfg_regs_t r;
    r.fen = strap_fen(s);
    r.map = strap_map(s);
    r.pwr = (s == 5'd31) ? 8'h02 : 8'h00;
    return r;
  endfunction

  // alternate UART bases for fields 2 (even) and 3 (odd)
  function automatic logic [11:0] uart_alt_base(input logic odd, input logic [1:0] sel);
    if (odd) begin
      case (sel)
        2'd0:    return 12'h2E8;
        2'd1:    return 12'h238;
        2'd2:    return 12'h2E0;
        default: return 12'h228;
      endcase
    end else begin
      case (sel)
        2'd0:    return 12'h3E8;
        2'd1:    return 12'h338;
        2'd2:    return 12'h2E8;
        default: return 12'h220;
      endcase
    end
  endfunction
endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] strap_i,
  input  logic          sel_i,
  input  logic          data_port_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output cfg_regs_t     regs_o
);
  logic [DW-1:0] idx_q;
  id_step_e      step_q;
  cfg_regs_t     regs_q;
  logic          idx_ok;
  logic [DW-1:0] reg_rd;

  assign idx_ok = idx_q < DW'(REG_NUM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      step_q <= ID_S0;
      regs_q <= strap_defaults(strap_i);
    end else if (sel_i && wr_i) begin
      if (!data_port_i) begin
        idx_q  <= wdata_i;
        step_q <= ID_END;
      end else if (idx_ok) begin
        case (idx_q[1:0])
          2'd0:    regs_q.fen <= wdata_i;
          2'd1:    regs_q.map <= wdata_i;
          default: regs_q.pwr <= wdata_i;
        endcase
      end
    end else if (sel_i && rd_i && !data_port_i) begin
      case (step_q)
        ID_S0:   step_q <= ID_S1;
        ID_S1:   step_q <= ID_END;
        default: step_q <= ID_END;
      endcase
    end
  end

  always_comb begin
    case (idx_q[1:0])
      2'd0:    reg_rd = regs_q.fen;
      2'd1:    reg_rd = regs_q.map;
      default: reg_rd = regs_q.pwr;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && rd_i) begin
      if (!data_port_i) begin
        case (step_q)
          ID_S0:   rdata_o = ID_FIRST;
          ID_S1:   rdata_o = ID_SECOND;
          default: rdata_o = idx_q;
        endcase
      end else if (idx_ok) begin
        rdata_o = reg_rd;
      end
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/sio_cfg_uart_map.sv
module sio_cfg_uart_map
  import sio_cfg_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IRQ_W = 4
) (
  input  logic [1:0]       field_i,
  input  logic [1:0]       alt_sel_i,
  output logic [AW-1:0]    base_o,
  output logic [IRQ_W-1:0] irq_o
);
  always_comb begin
    case (field_i)
      2'd0:    base_o = AW'(12'h3F8);
      2'd1:    base_o = AW'(12'h2F8);
      default: base_o = AW'(uart_alt_base(field_i[0], alt_sel_i));
    endcase
  end

  assign irq_o = field_i[0] ? IRQ_W'(3) : IRQ_W'(4);
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IRQ_W = 4
) (
  input  logic [7:0]                   fen_i,
  input  logic [7:0]                   map_i,
  input  logic                         par_irq7_i,
  output logic                         par_en_o,
  output logic [AW-1:0]                par_base_o,
  output logic [IRQ_W-1:0]             par_irq_o,
  output logic [UART_NUM-1:0]          uart_en_o,
  output logic [UART_NUM-1:0][AW-1:0]  uart_base_o,
  output logic [UART_NUM-1:0][IRQ_W-1:0] uart_irq_o,
  output logic                         fdc_en_o,
  output logic [AW-1:0]                fdc_base_o,
  output logic [IRQ_W-1:0]             fdc_irq_o,
  output logic                         ide_en_o,
  output logic [AW-1:0]                ide_base_o,
  output logic [AW-1:0]                ide_alt_base_o,
  output logic [IRQ_W-1:0]             ide_irq_o
);
  localparam int IDE_ALT_OFS = 'h206;

  assign par_en_o = fen_i[0];
  assign fdc_en_o = fen_i[3];
  assign ide_en_o = fen_i[6];

  always_comb begin
    case (map_i[1:0])
      2'd0: begin
        par_base_o = AW'(12'h378);
        par_irq_o  = par_irq7_i ? IRQ_W'(7) : IRQ_W'(5);
      end
      2'd1: begin
        par_base_o = AW'(12'h3BC);
        par_irq_o  = IRQ_W'(7);
      end
      2'd2: begin
        par_base_o = AW'(12'h278);
        par_irq_o  = IRQ_W'(5);
      end
      default: begin
        par_base_o = '0;
        par_irq_o  = '0;
      end
    endcase
  end

  for (genvar g = 0; g < UART_NUM; g++) begin : g_uart
    assign uart_en_o[g] = fen_i[1+g];
    sio_cfg_uart_map #(
      .AW   (AW),
      .IRQ_W(IRQ_W)
    ) u_map (
      .field_i  (map_i[2*g+3:2*g+2]),
      .alt_sel_i(map_i[7:6]),
      .base_o   (uart_base_o[g]),
      .irq_o    (uart_irq_o[g])
    );
  end

  assign fdc_base_o     = fen_i[5] ? AW'(12'h370) : AW'(12'h3F0);
  assign fdc_irq_o      = IRQ_W'(6);
  assign ide_base_o     = fen_i[7] ? AW'(12'h170) : AW'(12'h1F0);
  assign ide_alt_base_o = ide_base_o + AW'(IDE_ALT_OFS);
  assign ide_irq_o      = IRQ_W'(14);
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int              IO_AW     = 16,
  parameter int              IRQ_W     = 4,
  parameter logic [IO_AW-1:0] BASE_ADDR = 16'h0398
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [4:0]                      strap_i,
  input  logic [IO_AW-1:0]                addr_i,
  input  logic                            wr_i,
  input  logic                            rd_i,
  input  logic [7:0]                      wdata_i,
  output logic [7:0]                      rdata_o,
  output logic                            par_en_o,
  output logic [IO_AW-1:0]                par_base_o,
  output logic [IRQ_W-1:0]                par_irq_o,
  output logic [1:0]                      uart_en_o,
  output logic [1:0][IO_AW-1:0]           uart_base_o,
  output logic [1:0][IRQ_W-1:0]           uart_irq_o,
  output logic                            fdc_en_o,
  output logic [IO_AW-1:0]                fdc_base_o,
  output logic [IRQ_W-1:0]                fdc_irq_o,
  output logic                            ide_en_o,
  output logic [IO_AW-1:0]                ide_base_o,
  output logic [IO_AW-1:0]                ide_alt_base_o,
  output logic [IRQ_W-1:0]                ide_irq_o
);
  logic      sel;
  cfg_regs_t regs;

  assign sel = addr_i[IO_AW-1:1] == BASE_ADDR[IO_AW-1:1];

  sio_cfg_regs #(
    .DW(8),
    .SW(5)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_i    (strap_i),
    .sel_i      (sel),
    .data_port_i(addr_i[0]),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .regs_o     (regs)
  );

  sio_cfg_decode #(
    .AW   (IO_AW),
    .IRQ_W(IRQ_W)
  ) u_decode (
    .fen_i         (regs.fen),
    .map_i         (regs.map),
    .par_irq7_i    (regs.pwr[3]),
    .par_en_o      (par_en_o),
    .par_base_o    (par_base_o),
    .par_irq_o     (par_irq_o),
    .uart_en_o     (uart_en_o),
    .uart_base_o   (uart_base_o),
    .uart_irq_o    (uart_irq_o),
    .fdc_en_o      (fdc_en_o),
    .fdc_base_o    (fdc_base_o),
    .fdc_irq_o     (fdc_irq_o),
    .ide_en_o      (ide_en_o),
    .ide_base_o    (ide_base_o),
    .ide_alt_base_o(ide_alt_base_o),
    .ide_irq_o     (ide_irq_o)
  );
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int               IO_AW     = 16,
  parameter int               IRQ_W     = 4,
  parameter logic [IO_AW-1:0] BASE_ADDR = 16'h0398
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [IO_AW-1:0]      addr_i,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [7:0]            rdata_o,
  input logic [IO_AW-1:0]      par_base_o,
  input logic [IRQ_W-1:0]      par_irq_o,
  input logic [1:0][IO_AW-1:0] uart_base_o,
  input logic [1:0][IRQ_W-1:0] uart_irq_o,
  input logic [IO_AW-1:0]      fdc_base_o,
  input logic [IO_AW-1:0]      ide_base_o,
  input logic [IO_AW-1:0]      ide_alt_base_o
);
  // R5
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 8'h00);

  // R5
  addr_miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[IO_AW-1:1] != BASE_ADDR[IO_AW-1:1]) |-> rdata_o == 8'h00);

  // R6
  ide_alt_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ide_alt_base_o == ide_base_o + IO_AW'('h206));

  // R7
  par_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_base_o == '0 |-> par_irq_o == '0);

  // R8
  uart0_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uart_irq_o[0] == IRQ_W'(3) || uart_irq_o[0] == IRQ_W'(4));

  // R8
  uart1_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uart_irq_o[1] == IRQ_W'(3) || uart_irq_o[1] == IRQ_W'(4));

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(par_base_o) && $stable(uart_base_o) &&
              $stable(fdc_base_o) && $stable(ide_base_o));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .IO_AW    (IO_AW),
  .IRQ_W    (IRQ_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wr_i          (wr_i),
  .rd_i          (rd_i),
  .rdata_o       (rdata_o),
  .par_base_o    (par_base_o),
  .par_irq_o     (par_irq_o),
  .uart_base_o   (uart_base_o),
  .uart_irq_o    (uart_irq_o),
  .fdc_base_o    (fdc_base_o),
  .ide_base_o    (ide_base_o),
  .ide_alt_base_o(ide_alt_base_o)
);

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
  localparam logic [15:0] BA = 16'h0398;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [4:0] strap = 5'd1;
  logic [15:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic par_en, fdc_en, ide_en;
  logic [15:0] par_base, fdc_base, ide_base, ide_alt;
  logic [3:0] par_irq, fdc_irq, ide_irq;
  logic [1:0] uart_en;
  logic [1:0][15:0] uart_base;
  logic [1:0][3:0] uart_irq;

  always #10 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .par_en_o(par_en), .par_base_o(par_base), .par_irq_o(par_irq),
    .uart_en_o(uart_en), .uart_base_o(uart_base), .uart_irq_o(uart_irq),
    .fdc_en_o(fdc_en), .fdc_base_o(fdc_base), .fdc_irq_o(fdc_irq),
    .ide_en_o(ide_en), .ide_base_o(ide_base), .ide_alt_base_o(ide_alt),
    .ide_irq_o(ide_irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int m_idx, m_step;
  int m_reg[3];
  int def_fen[32] = '{'h4f,'h4f,'h4f,'h4f,'h4f,'h4f,'h4b,'h4b,'h4b,'h4b,'h4b,'h4b,
                      'h0f,'h0f,'h0f,'h0f,'h49,'h49,'h49,'h49,'h07,'h07,'h07,'h07,
                      'h47,'h47,'h47,'h47,'h47,'h47,'h08,'h00};
  int def_map[32] = '{'h10,'h11,'h11,'h39,'h24,'h38,'h00,'h01,'h01,'h09,'h08,'h08,
                      'h10,'h11,'h39,'h24,'h00,'h01,'h01,'h00,'h10,'h11,'h39,'h24,
                      'h10,'h11,'h11,'h39,'h24,'h38,'h10,'h10};
  int alt2[4] = '{'h3e8, 'h338, 'h2e8, 'h220};
  int alt3[4] = '{'h2e8, 'h238, 'h2e0, 'h228};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    if (!rd || addr[15:1] != BA[15:1]) return 0;
    if (addr[0] == 1'b0) begin
      if (m_step == 0) return 'h88;
      if (m_step == 1) return 0;
      return m_idx;
    end
    return (m_idx < 3) ? m_reg[m_idx] : 0;
  endfunction

  task automatic compare_all(input string tag);
    int fen = m_reg[0], map = m_reg[1], pw = m_reg[2];
    int pf = map % 4;
    chk(tag, "rdata", int'(rdata), exp_rdata());
    chk("R6", "par_en", int'(par_en), (fen >> 0) & 1);
    chk("R6", "uart_en", int'(uart_en), (fen >> 1) & 3);
    chk("R6", "fdc_en", int'(fdc_en), (fen >> 3) & 1);
    chk("R6", "ide_en", int'(ide_en), (fen >> 6) & 1);
    chk("R6", "fdc_base", int'(fdc_base), ((fen & 'h20) != 0) ? 'h370 : 'h3f0);
    chk("R6", "ide_base", int'(ide_base), ((fen & 'h80) != 0) ? 'h170 : 'h1f0);
    chk("R6", "ide_alt", int'(ide_alt), (((fen & 'h80) != 0) ? 'h170 : 'h1f0) + 'h206);
    chk("R7", "par_base", int'(par_base), pf == 0 ? 'h378 : pf == 1 ? 'h3bc : pf == 2 ? 'h278 : 0);
    chk("R7", "par_irq", int'(par_irq),
        pf == 0 ? (((pw & 8) != 0) ? 7 : 5) : pf == 1 ? 7 : pf == 2 ? 5 : 0);
    for (int u = 0; u < 2; u++) begin
      int f = (map >> (2 * u + 2)) & 3;
      int b = f == 0 ? 'h3f8 : f == 1 ? 'h2f8 : f == 2 ? alt2[(map >> 6) & 3] : alt3[(map >> 6) & 3];
      chk("R8", "uart_base", int'(uart_base[u]), b);
      chk("R8", "uart_irq", int'(uart_irq[u]), (f % 2 == 1) ? 3 : 4);
    end
    chk("R9", "fdc_irq", int'(fdc_irq), 6);
    chk("R9", "ide_irq", int'(ide_irq), 14);
  endtask

  // one bus cycle: drive at falling edge, compare before rising edge, then advance model
  task automatic op(input logic [15:0] a, input bit w, input bit r, input logic [7:0] d,
                    input string tag);
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d;
    #8;
    compare_all(tag);
    @(posedge clk);
    #1;
    if (a[15:1] == BA[15:1]) begin
      if (w) begin
        if (!a[0]) begin m_idx = int'(d); m_step = 2; end
        else if (m_idx < 3) m_reg[m_idx] = int'(d);
      end else if (r && !a[0]) begin
        if (m_step < 2) m_step++;
      end
    end
  endtask

  task automatic idle(input string tag);  op(BA, 0, 0, 8'h00, tag); endtask
  task automatic wr_idx(input int v);     op(BA, 1, 0, 8'(v), "R3"); endtask
  task automatic wr_dat(input int v);     op(BA + 16'd1, 1, 0, 8'(v), "R4"); endtask
  task automatic rd_idx(input string t);  op(BA, 0, 1, 8'h00, t); endtask
  task automatic rd_dat(input string t);  op(BA + 16'd1, 0, 1, 8'h00, t); endtask

  task automatic do_reset(input int s);
    @(negedge clk);
    wr = 0; rd = 0;
    strap = 5'(s);
    #1 rst_ni = 1'b0;
    m_idx = 0; m_step = 0;
    m_reg[0] = def_fen[s]; m_reg[1] = def_map[s]; m_reg[2] = (s == 31) ? 2 : 0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1);
    // R1 defaults for strap 1
    idle("R1");
    rd_dat("R1");
    // R2 identification sequence, saturating
    rd_idx("R2"); rd_idx("R2"); rd_idx("R2"); rd_idx("R2"); rd_idx("R2");
    wr_idx(1); rd_dat("R1");
    wr_idx(2); rd_dat("R1");
    // R3 index write stored and readable
    wr_idx('hff); rd_idx("R3");
    // R4 out-of-range index
    wr_dat('h55); rd_dat("R4");
    wr_idx(3); wr_dat('haa); rd_dat("R4");
    wr_idx(0); wr_dat('h5a); rd_dat("R4");
    wr_idx(2); wr_dat('h08); rd_dat("R4");
    // R3 index write ends identification early
    do_reset(1);
    rd_idx("R2"); wr_idx(1); rd_idx("R3"); rd_idx("R3");
    // R2 data accesses do not advance the sequence
    do_reset(0);
    rd_dat("R2"); wr_dat('h4f); rd_dat("R2"); rd_idx("R2"); rd_dat("R2"); rd_idx("R2"); rd_idx("R2");
    // R5 foreign addresses
    op(16'h039a, 0, 1, 8'h00, "R5");
    op(16'h039b, 0, 1, 8'h00, "R5");
    op(16'h0198, 0, 1, 8'h00, "R5");
    op(16'h039a, 1, 0, 8'h02, "R5");
    op(16'h0299, 1, 0, 8'h00, "R5");
    op(BA, 0, 0, 8'h00, "R5");
    rd_idx("R5"); rd_dat("R5");
    // R10 decode sweeps
    foreach (def_fen[k]) begin
      if (k % 6 == 0) begin
        wr_idx(0); wr_dat((k * 37) & 'hff);
        idle("R10");
        wr_idx(2); wr_dat(((k / 6) % 2 == 1) ? 'h08 : 'h00);
        wr_idx(1);
        for (int m = 0; m < 256; m++) begin
          wr_dat(m);
          idle("R10");
        end
      end
    end
    wr_idx(0); wr_dat('hff); idle("R10");
    wr_dat('h00); idle("R10");
    // R1 other straps
    for (int i = 0; i < 6; i++) begin
      int s = (i == 0) ? 31 : (i == 1) ? 6 : (i == 2) ? 20 : (i == 3) ? 30 : (i == 4) ? 12 : 9;
      do_reset(s);
      idle("R1");
      rd_dat("R1");
      wr_idx(1); rd_dat("R1");
      wr_idx(2); rd_dat("R1");
    end
    // R2 reset restarts sequence mid-way
    rd_idx("R2");
    do_reset(3);
    rd_idx("R2"); rd_idx("R2"); rd_idx("R2");
    idle("R1");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule